// File: doc/BRIEF.md
# Exception Vector Fetch Sequencer

This block turns a pending exception into word reads of its vector over a simple request/acknowledge bus. After a synchronous reset it reads four words from program space, one at a time. They hold the initial bank/extension fields, the program counter, the stack pointer and the direct-page base. Each word goes into its own output register.

For any other exception, the block first forms an 8-bit vector number. That number is a fixed internal code, an autovector picked by the interrupt level, or a number supplied by an external device. The block then reads one word from data space at twice that number. A one-cycle `done` strobe returns the word and the vector number.

A bus error during the reset sequence stops the block until the next reset. A bus error during an ordinary vector read finishes that read with a fault flag set.

Top module: `exc_vector_fetch`

## Requirements
- R1: After reset the block issues four program-space reads (`bus_prog`=1) at byte addresses 0x0, 0x2, 0x4 and 0x6, in that order, one per acknowledge.
- R2: The four reset words are latched, in fetch order, into `rst_ext`, `rst_pc`, `rst_sp` and `rst_iz`. On completion `done` pulses with `vec_num`=0 and `vec_word` equal to the fourth word.
- R3: A read keeps `bus_req` high, with address and space held steady, until `bus_ack` or `bus_err` is sampled.
- R4: Exception kind codes 0..4 (breakpoint, bus error, software interrupt, illegal instruction, divide by zero) give vector numbers 4, 5, 6, 7 and 8.
- R5: Kind code 5 (autovector) with `exc_level` L in 1..7 gives vector 0x10+L. Level 0 gives the spurious vector 0x18.
- R6: Kind code 6 (spurious) gives vector 0x18. Kind code 7 (uninitialized) and the unused codes 9..15 give vector 0x0F.
- R7: Kind code 8 (external device) uses `ext_vec` unchanged as the vector number, for example 0x38..0xFF for user interrupts.
- R8: A non-reset vector read goes to data space (`bus_prog`=0) at byte address vector×2, which always falls below 0x200.
- R9: `done` is high for exactly one cycle per completed fetch, and `vec_word` carries the word returned with the acknowledge.
- R10: `bus_err` during the reset sequence sets `halted`. After that no bus request is issued until the next reset.
- R11: `bus_err` during a non-reset vector read ends it with `done`=1, `vec_fault`=1 and `vec_word`=0. A normal completion clears `vec_fault`.
- R12: `exc_req` is only sampled while the block is idle. While a read is in flight, or while the block is halted, a request has no effect.
- R13: Directly after reset `bus_req`=1, `bus_prog`=1, `bus_addr`=0, and `done`, `halted` and all four reset-word registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the reset fetch |
| exc_req | input | 1 | Exception pending, sampled when idle |
| exc_kind | input | 4 | Exception kind code |
| exc_level | input | 3 | Interrupt level for autovectored kind |
| ext_vec | input | 8 | Vector number supplied by an external device |
| bus_req | output | 1 | Word read request |
| bus_addr | output | ADDR_W | Byte address of the word |
| bus_prog | output | 1 | 1 = program space, 0 = data space |
| bus_ack | input | 1 | Read completed, data valid |
| bus_err | input | 1 | Read terminated with bus error |
| bus_rdata | input | WORD_W | Read data |
| done | output | 1 | One-cycle completion strobe |
| vec_num | output | 8 | Vector number of the completed fetch |
| vec_word | output | WORD_W | Fetched vector word |
| vec_fault | output | 1 | Last non-reset fetch ended in bus error |
| halted | output | 1 | Reset sequence failed; waits for reset |
| rst_ext | output | WORD_W | First reset word (extension fields) |
| rst_pc | output | WORD_W | Second reset word (program counter) |
| rst_sp | output | WORD_W | Third reset word (stack pointer) |
| rst_iz | output | WORD_W | Fourth reset word (direct-page base) |

## Verification
The bench varies acknowledge latency from zero to several cycles. A design that moves the address or drops the request before the acknowledge would read the wrong word or leave a read hanging. It walks every kind code, all autovector levels including level 0, and external numbers at both ends of the user range. An off-by-one in the lookup or a missing shift would show up as a wrong data-space address.

The bench raises a request while a read is in flight. A design that accepted it would change `vec_num` in the middle of the read. It injects bus errors at the second reset word and during an ordinary read. A design that kept fetching after a reset-time error, or returned stale data without the fault flag, would then differ from the reference model.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int VEC_W = 8;

  typedef enum logic [3:0] {
    K_BKPT   = 4'd0,
    K_BERR   = 4'd1,
    K_SWI    = 4'd2,
    K_ILL    = 4'd3,
    K_DIVZ   = 4'd4,
    K_AUTO   = 4'd5,
    K_SPUR   = 4'd6,
    K_UNINIT = 4'd7,
    K_EXT    = 4'd8
  } exc_kind_e;

  localparam logic [VEC_W-1:0] V_FIXED_BASE = 8'h04;
  localparam logic [VEC_W-1:0] V_AUTO_BASE  = 8'h10;
  localparam logic [VEC_W-1:0] V_SPUR       = 8'h18;
  localparam logic [VEC_W-1:0] V_UNINIT     = 8'h0F;

  typedef enum logic [1:0] {
    S_RFETCH = 2'd0,
    S_IDLE   = 2'd1,
    S_VFETCH = 2'd2,
    S_HALT   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/exc_vec_map.sv
module exc_vec_map
  import exc_vec_pkg::*;
(
  input  logic [3:0]       kind,
  input  logic [2:0]       level,
  input  logic [VEC_W-1:0] ext_vec,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    unique case (kind)
      K_BKPT, K_BERR, K_SWI, K_ILL, K_DIVZ:
        vec = V_FIXED_BASE + VEC_W'(kind);
      K_AUTO:
        vec = (level == 3'd0) ? V_SPUR : (V_AUTO_BASE | VEC_W'(level));
      K_SPUR:
        vec = V_SPUR;
      K_EXT:
        vec = ext_vec;
      default:
        vec = V_UNINIT;
    endcase
  end
endmodule

// File: rtl/exc_rst_bank.sv
module exc_rst_bank #(
  parameter int WORD_W = 16,
  parameter int NWORDS = 4,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q [NWORDS]
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        q[g] <= '0;
      end else if (we && idx == IDX_W'(g)) begin
        q[g] <= d;
      end
    end
  end
endmodule

// File: rtl/exc_vector_fetch.sv
module exc_vector_fetch
  import exc_vec_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_req,
  input  logic [3:0]        exc_kind,
  input  logic [2:0]        exc_level,
  input  logic [7:0]        ext_vec,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_prog,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              done,
  output logic [7:0]        vec_num,
  output logic [WORD_W-1:0] vec_word,
  output logic              vec_fault,
  output logic              halted,
  output logic [WORD_W-1:0] rst_ext,
  output logic [WORD_W-1:0] rst_pc,
  output logic [WORD_W-1:0] rst_sp,
  output logic [WORD_W-1:0] rst_iz
);
  localparam int RST_WORDS = 4;
  localparam int IDX_W     = $clog2(RST_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RST_WORDS - 1);

  seq_state_e       st;
  logic [IDX_W-1:0] idx;
  logic [VEC_W-1:0] map_vec;
  logic             bank_we;
  logic [WORD_W-1:0] bank_q [RST_WORDS];

  exc_vec_map i_map (
    .kind    (exc_kind),
    .level   (exc_level),
    .ext_vec (ext_vec),
    .vec     (map_vec)
  );

  assign bank_we = (st == S_RFETCH) && bus_ack && !bus_err;

  exc_rst_bank #(.WORD_W(WORD_W), .NWORDS(RST_WORDS)) i_bank (
    .clk (clk),
    .rst (rst),
    .we  (bank_we),
    .idx (idx),
    .d   (bus_rdata),
    .q   (bank_q)
  );

  assign rst_ext = bank_q[0];
  assign rst_pc  = bank_q[1];
  assign rst_sp  = bank_q[2];
  assign rst_iz  = bank_q[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_RFETCH;
      idx       <= '0;
      bus_req   <= 1'b1;
      bus_addr  <= '0;
      bus_prog  <= 1'b1;
      done      <= 1'b0;
      vec_fault <= 1'b0;
      vec_num   <= '0;
      vec_word  <= '0;
      halted    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_RFETCH: begin
          if (bus_err) begin
            bus_req <= 1'b0;
            halted  <= 1'b1;
            st      <= S_HALT;
          end else if (bus_ack) begin
            if (idx == LAST_IDX) begin
              bus_req   <= 1'b0;
              done      <= 1'b1;
              vec_fault <= 1'b0;
              vec_num   <= '0;
              vec_word  <= bus_rdata;
              st        <= S_IDLE;
            end else begin
              idx      <= idx + IDX_W'(1);
              bus_addr <= ADDR_W'({idx + IDX_W'(1), 1'b0});
            end
          end
        end
        S_IDLE: begin
          if (exc_req) begin
            vec_num  <= map_vec;
            bus_addr <= ADDR_W'({map_vec, 1'b0});
            bus_prog <= 1'b0;
            bus_req  <= 1'b1;
            st       <= S_VFETCH;
          end
        end
        S_VFETCH: begin
          if (bus_err) begin
            bus_req   <= 1'b0;
            done      <= 1'b1;
            vec_fault <= 1'b1;
            vec_word  <= '0;
            st        <= S_IDLE;
          end else if (bus_ack) begin
            bus_req   <= 1'b0;
            done      <= 1'b1;
            vec_fault <= 1'b0;
            vec_word  <= bus_rdata;
            st        <= S_IDLE;
          end
        end
        default: begin
          bus_req <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/exc_vector_fetch_chk.sv
module exc_vector_fetch_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_err,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_prog,
  input logic              done,
  input logic              vec_fault,
  input logic              halted
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && !bus_err) |=> (bus_req && $stable(bus_addr) && $stable(bus_prog)));

  p_prog_window_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_prog) |-> (bus_addr <= ADDR_W'(6) && !bus_addr[0]));

  p_data_table_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_prog) |-> (bus_addr < ADDR_W'(512) && !bus_addr[0]));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !bus_req));

  p_fault_with_done_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_fault) |-> done);
endmodule

bind exc_vector_fetch exc_vector_fetch_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_err   (bus_err),
  .bus_addr  (bus_addr),
  .bus_prog  (bus_prog),
  .done      (done),
  .vec_fault (vec_fault),
  .halted    (halted)
);

// File: tb/test_exc_vector_fetch.sv
`timescale 1ns/1ps
module test_exc_vector_fetch;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exc_req = 1'b0;
  logic [3:0] exc_kind = '0;
  logic [2:0] exc_level = '0;
  logic [7:0] ext_vec = '0;
  logic bus_req, bus_prog, done, vec_fault, halted;
  logic [ADDR_W-1:0] bus_addr;
  logic bus_ack = 1'b0, bus_err = 1'b0;
  logic [WORD_W-1:0] bus_rdata = '0;
  logic [7:0] vec_num;
  logic [WORD_W-1:0] vec_word, rst_ext, rst_pc, rst_sp, rst_iz;

  exc_vector_fetch #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_exc_vector_fetch (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_kind(exc_kind),
    .exc_level(exc_level), .ext_vec(ext_vec), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_prog(bus_prog), .bus_ack(bus_ack),
    .bus_err(bus_err), .bus_rdata(bus_rdata), .done(done),
    .vec_num(vec_num), .vec_word(vec_word), .vec_fault(vec_fault),
    .halted(halted), .rst_ext(rst_ext), .rst_pc(rst_pc),
    .rst_sp(rst_sp), .rst_iz(rst_iz)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int lat = 0;
  int resp_cnt = 0;
  int err_at = -1;
  int wait_cnt = 0;
  bit started = 0;

  function automatic logic [15:0] mem_word(input bit prog, input int a);
    return prog ? (16'hC000 | 16'(a)) : (16'h3000 ^ 16'(a * 3));
  endfunction

  function automatic logic [7:0] ref_vec(input int k, input int l, input int e);
    if (k <= 4) return 8'(4 + k);
    if (k == 5) return (l == 0) ? 8'h18 : 8'(16 + l);
    if (k == 6) return 8'h18;
    if (k == 8) return 8'(e);
    return 8'h0F;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // bus responder
  always @(negedge clk) begin
    if (bus_ack || bus_err) begin
      bus_ack <= 1'b0; bus_err <= 1'b0; wait_cnt <= 0;
    end else if (bus_req) begin
      if (wait_cnt >= lat) begin
        resp_cnt <= resp_cnt + 1;
        if (resp_cnt == err_at) bus_err <= 1'b1;
        else bus_ack <= 1'b1;
        bus_rdata <= mem_word(bus_prog, int'(bus_addr));
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  // behavioural reference model
  int m_st, m_idx;
  bit m_req, m_prog, m_done, m_fault, m_halt;
  int m_addr, m_vnum;
  logic [15:0] m_vword;
  logic [15:0] m_regs [4];

  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (rst) begin
      m_st = 0; m_idx = 0; m_req = 1; m_addr = 0; m_prog = 1; m_done = 0;
      m_fault = 0; m_halt = 0; m_vnum = 0; m_vword = 0;
      foreach (m_regs[i]) m_regs[i] = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (bus_err) begin m_req = 0; m_halt = 1; m_st = 3; end
           else if (bus_ack) begin
             m_regs[m_idx] = bus_rdata;
             if (m_idx == 3) begin
               m_req = 0; m_done = 1; m_fault = 0; m_vnum = 0; m_vword = bus_rdata; m_st = 1;
             end else begin m_idx++; m_addr = m_idx * 2; end
           end
        1: if (exc_req) begin
             m_vnum = ref_vec(exc_kind, exc_level, ext_vec);
             m_addr = m_vnum * 2; m_prog = 0; m_req = 1; m_st = 2;
           end
        2: if (bus_err) begin m_req = 0; m_done = 1; m_fault = 1; m_vword = 0; m_st = 1; end
           else if (bus_ack) begin m_req = 0; m_done = 1; m_fault = 0; m_vword = bus_rdata; m_st = 1; end
        default: m_req = 0;
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk(bus_req == m_req, "R3 bus_req", 32'(bus_req), 32'(m_req));
      chk(int'(bus_addr) == m_addr, "R8 bus_addr", 32'(bus_addr), 32'(m_addr));
      chk(bus_prog == m_prog, "R1 bus_prog", 32'(bus_prog), 32'(m_prog));
      chk(done == m_done, "R9 done", 32'(done), 32'(m_done));
      chk(int'(vec_num) == m_vnum, "R4 vec_num", 32'(vec_num), 32'(m_vnum));
      chk(vec_word == m_vword, "R9 vec_word", 32'(vec_word), 32'(m_vword));
      chk(vec_fault == m_fault, "R11 vec_fault", 32'(vec_fault), 32'(m_fault));
      chk(halted == m_halt, "R10 halted", 32'(halted), 32'(m_halt));
      chk(rst_ext == m_regs[0] && rst_pc == m_regs[1] && rst_sp == m_regs[2] && rst_iz == m_regs[3],
          "R2 reset words", {rst_ext, rst_pc}, {m_regs[0], m_regs[1]});
    end
  end

  // watchdog
  initial begin
    #(5ns * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wait_done();
    for (int i = 0; i < 60 && !done; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(bus_req && bus_prog && bus_addr == 0 && !done && !halted && rst_pc == 0,
        "R13 reset state", {bus_req, bus_prog, done, halted}, 32'hC);
    rst = 1'b0;
  endtask

  task automatic do_exc(input int k, input int l, input int e, input logic [7:0] exp, input string tag);
    @(negedge clk);
    exc_kind = 4'(k); exc_level = 3'(l); ext_vec = 8'(e); exc_req = 1'b1;
    @(negedge clk);
    exc_req = 1'b0;
    // stray request while the read is in flight (R12)
    exc_kind = 4'd3; exc_req = 1'b1;
    @(negedge clk);
    exc_req = 1'b0;
    wait_done();
    chk(done && vec_num == exp, tag, 32'(vec_num), 32'(exp));
    chk(vec_word == (vec_fault ? 16'h0 : mem_word(0, int'(exp) * 2)), "R8 data word at vec*2",
        32'(vec_word), 32'(mem_word(0, int'(exp) * 2)));
  endtask

  initial begin
    lat = 0;
    do_reset();
    wait_done();
    chk(done && vec_num == 0 && vec_word == 16'hC006, "R2 reset done", 32'(vec_word), 32'hC006);
    chk(rst_ext == 16'hC000 && rst_pc == 16'hC002 && rst_sp == 16'hC004 && rst_iz == 16'hC006,
        "R1 reset fetch order", {rst_ext, rst_iz}, 32'hC000C006);

    for (int k = 0; k <= 4; k++) begin
      lat = k % 3;
      do_exc(k, 0, 0, 8'(4 + k), "R4 fixed vector");
    end
    for (int l = 0; l <= 7; l++) begin
      lat = l % 4;
      do_exc(5, l, 0, (l == 0) ? 8'h18 : 8'(8'h10 + l), "R5 autovector");
    end
    do_exc(6, 0, 0, 8'h18, "R6 spurious");
    do_exc(7, 0, 0, 8'h0F, "R6 uninitialized");
    do_exc(12, 0, 0, 8'h0F, "R6 unused kind");
    do_exc(8, 0, 8'h38, 8'h38, "R7 external low");
    do_exc(8, 0, 8'hFF, 8'hFF, "R7 external high");
    lat = 2;
    do_exc(8, 0, 8'h9A, 8'h9A, "R12 stray request ignored");

    // bus error on an ordinary fetch
    err_at = resp_cnt;
    @(negedge clk);
    do_exc(0, 0, 0, 8'h04, "R11 faulted fetch number");
    chk(vec_fault && vec_word == 0, "R11 fault flag", {vec_fault, vec_word}, 32'h10000);
    do_exc(1, 0, 0, 8'h05, "R11 fault cleared");
    chk(!vec_fault, "R11 fault cleared flag", 32'(vec_fault), 0);

    // bus error on the second reset word
    lat = 1;
    @(negedge clk);
    err_at = resp_cnt + 1;
    do_reset();
    for (int i = 0; i < 12; i++) @(negedge clk);
    chk(halted && !bus_req, "R10 halted after reset error", {halted, bus_req}, 32'h2);
    chk(rst_ext == 16'hC000 && rst_pc == 0, "R10 partial reset words", {rst_ext, rst_pc}, 32'hC0000000);
    exc_kind = 4'd2; exc_req = 1'b1;
    for (int i = 0; i < 6; i++) @(negedge clk);
    exc_req = 1'b0;
    chk(!bus_req && halted && !done, "R12 request ignored while halted", {bus_req, halted}, 32'h1);

    // recovery
    err_at = -1;
    lat = 0;
    do_reset();
    wait_done();
    chk(!halted && rst_sp == 16'hC004, "R10 reset clears halt", {halted, rst_sp}, 32'h0C004);
    do_exc(4, 0, 0, 8'h08, "R4 after recovery");

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule